// File: doc/BRIEF.md
# Dual-Channel PWM Generator

This block drives two pulse-width-modulated outputs. Software configures it through a small bank of 32-bit registers on a simple memory-mapped bus. Writes are accepted on a single-cycle write strobe and reads are combinational. Each channel has a period value (RNG, counted in PWM clocks) and an on-count (DAT). The PWM clock is not a separate clock. It is a one-cycle enable, `pwm_tick`, sampled on the system clock, and every tick produces one output bit per channel.

Each channel has one of two waveforms. In mark/space form the output is one contiguous high pulse at the start of each period. In spread form the same number of high ticks is scattered as evenly as possible across the period by an accumulator. Each channel also has an enable, a silence level that is driven while the channel is off, and a polarity inversion. The inversion is applied last, so it also acts on the silence level. Some control bits exist only so the layout stays compatible: the serializer select, repeat-last and queue-select bits. They are stored and read back but have no effect.

Each channel is sequenced by a three-state machine. CH_IDLE is the disabled state, CH_MARKSPACE is the contiguous-pulse state and CH_SPREAD is the dithered state. The transitions are:
- ENABLE: CH_IDLE to either running state, chosen by the waveform bit.
- DISABLE: either running state back to CH_IDLE.
- SWITCH: one running state to the other when the waveform bit changes.

Any transition clears the period counter, the accumulator and the registered output bit.

Top module: `pwm_pair`

## Requirements
- R1: After reset the control word (offset 0x00) reads 0. Both channels' RNG registers read 10000 and both DAT registers read 2500. Both outputs are 0.
- R2: The registers sit at fixed offsets: control at 0x00, channel 0 RNG at 0x10 and DAT at 0x14, channel 1 RNG at 0x20 and DAT at 0x24. The RNG and DAT registers hold full 32-bit values. Offset 0x04 (status) and every other offset read 0, and writes to them change nothing.
- R3: Control bits 6 and 14, and bits 31:16, always read 0. All other bits of 15:0 read back as written.
- R4: For channel n, with control bit base b=8n: bit b is the enable, bit b+3 is the silence level, bit b+4 is the inversion and bit b+7 selects mark/space (1) or spread (0). While a channel is disabled its output equals silence XOR inversion, whatever `pwm_tick` does.
- R5: In mark/space form, tick k (k=0 at the first tick after enabling) gives a high output exactly when (k mod RNG) < DAT.
- R6: In spread form, the accumulator starts at 0. Each tick adds min(DAT,RNG). When the sum is at least RNG, RNG is subtracted and the tick's bit is 1. Otherwise the bit is 0.
- R7: In both forms, DAT=0 gives a constantly low bit and DAT>=RNG (with DAT nonzero) gives a constantly high bit.
- R8: While a channel is enabled its output is the waveform bit XOR the inversion bit. Before the first tick, that bit is 0.
- R9: A channel's output changes only on a clock edge where `pwm_tick` was high, or after a control write.
- R10: Disabling a channel and then enabling it again restarts its waveform at k=0 with the accumulator at 0. This holds when the first tick comes at least two clock edges after the enabling write.
- R11: The two channels run independently, each with its own form, period, on-count and levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_tick | input | 1 | PWM clock enable, one output step per high cycle |
| pwm_out | output | 2 | Channel outputs, bit n for channel n |

## Verification
A stale period counter or accumulator shows up at the output on the first tick after enabling. The bench restarts the channel before each run and compares every single tick against an independent model, so a wrong phase or a missed subtraction is caught within one period. A state machine stuck in the wrong state shows at once: a disabled channel fails to hold its silence level, or the wrong waveform shape appears in the first period. Stability between ticks is checked in every idle cycle of the gapped runs, so an output that advances without a tick shows up within one cycle.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_MARKSPACE,
        CH_SPREAD
    } ch_state_e;

    // control bit positions inside one channel's byte
    localparam int CTL_EN        = 0;
    localparam int CTL_SILENCE   = 3;
    localparam int CTL_INVERT    = 4;
    localparam int CTL_MARKSPACE = 7;
    localparam int CTL_STRIDE    = 8;

    // bit 6 is a clear strobe, bit 14 is unused: neither is kept
    localparam logic [15:0] CTL_KEEP_MASK = 16'hBFBF;

    localparam logic [7:0] OFS_CTL = 8'h00;

    function automatic logic [7:0] ch_reg_ofs(input int ch, input bit is_dat);
        return 8'(16 + ch * 16 + (is_dat ? 4 : 0));
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pair_pkg::*;
#(
    parameter int          DW      = 32,
    parameter int          AW      = 8,
    parameter logic [31:0] RNG_RST = 32'd10000,
    parameter logic [31:0] DAT_RST = 32'd2500
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [AW-1:0]               bus_addr,
    input  logic [DW-1:0]               bus_wdata,
    output logic [DW-1:0]               bus_rdata,
    output logic [NUM_CH-1:0]           en_o,
    output logic [NUM_CH-1:0]           ms_o,
    output logic [NUM_CH-1:0]           sil_o,
    output logic [NUM_CH-1:0]           inv_o,
    output logic [NUM_CH-1:0][DW-1:0]   rng_o,
    output logic [NUM_CH-1:0][DW-1:0]   dat_o
);

    localparam int CTL_W = NUM_CH * CTL_STRIDE;

    logic [CTL_W-1:0]             ctl_q;
    logic [NUM_CH-1:0][DW-1:0]    rng_q;
    logic [NUM_CH-1:0][DW-1:0]    dat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int c = 0; c < NUM_CH; c++) begin
                rng_q[c] <= DW'(RNG_RST);
                dat_q[c] <= DW'(DAT_RST);
            end
        end else if (bus_wr) begin
            if (bus_addr == AW'(OFS_CTL))
                ctl_q <= bus_wdata[CTL_W-1:0] & CTL_KEEP_MASK;
            for (int c = 0; c < NUM_CH; c++) begin
                if (bus_addr == AW'(ch_reg_ofs(c, 1'b0))) rng_q[c] <= bus_wdata;
                if (bus_addr == AW'(ch_reg_ofs(c, 1'b1))) dat_q[c] <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFS_CTL))
            bus_rdata = DW'(ctl_q);
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == AW'(ch_reg_ofs(c, 1'b0))) bus_rdata = rng_q[c];
            if (bus_addr == AW'(ch_reg_ofs(c, 1'b1))) bus_rdata = dat_q[c];
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_fields
        assign en_o[c]  = ctl_q[c*CTL_STRIDE + CTL_EN];
        assign ms_o[c]  = ctl_q[c*CTL_STRIDE + CTL_MARKSPACE];
        assign sil_o[c] = ctl_q[c*CTL_STRIDE + CTL_SILENCE];
        assign inv_o[c] = ctl_q[c*CTL_STRIDE + CTL_INVERT];
    end

    assign rng_o = rng_q;
    assign dat_o = dat_q;

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pair_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          markspace,
    input  logic          silence,
    input  logic          invert,
    input  logic [DW-1:0] rng,
    input  logic [DW-1:0] dat,
    output logic          out
);

    ch_state_e state_q, state_d;

    logic [DW-1:0] cnt_q;
    logic [DW-1:0] acc_q;
    logic          bit_q;

    logic [DW-1:0] dat_eff;
    logic [DW:0]   acc_sum;
    logic [DW:0]   acc_left;
    logic [DW:0]   cnt_inc;
    logic          sum_wrap;
    logic          cnt_wrap;
    logic          ms_level;
    logic          sp_level;
    logic          restart;

    // next state: ENABLE, DISABLE and SWITCH transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:      if (en) state_d = markspace ? CH_MARKSPACE : CH_SPREAD;
            CH_MARKSPACE: if (!en) state_d = CH_IDLE;
                          else if (!markspace) state_d = CH_SPREAD;
            CH_SPREAD:    if (!en) state_d = CH_IDLE;
                          else if (markspace) state_d = CH_MARKSPACE;
            default:      state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        dat_eff  = (dat > rng) ? rng : dat;
        acc_sum  = {1'b0, acc_q} + {1'b0, dat_eff};
        acc_left = acc_sum - {1'b0, rng};
        sum_wrap = acc_sum >= {1'b0, rng};
        cnt_inc  = {1'b0, cnt_q} + (DW+1)'(1);
        cnt_wrap = cnt_inc >= {1'b0, rng};
        ms_level = (dat != '0) && ((cnt_q < dat) || (dat >= rng));
        sp_level = (dat != '0) && sum_wrap;
        restart  = (state_q == CH_IDLE) || (state_d != state_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            acc_q <= '0;
            bit_q <= 1'b0;
        end else if (restart) begin
            cnt_q <= '0;
            acc_q <= '0;
            bit_q <= 1'b0;
        end else if (tick) begin
            unique case (state_q)
                CH_MARKSPACE: begin
                    bit_q <= ms_level;
                    cnt_q <= cnt_wrap ? '0 : cnt_inc[DW-1:0];
                end
                CH_SPREAD: begin
                    bit_q <= sp_level;
                    acc_q <= sum_wrap ? acc_left[DW-1:0] : acc_sum[DW-1:0];
                end
                default: bit_q <= 1'b0;
            endcase
        end
    end

    // output process: silence selection first, inversion last
    always_comb begin
        if (state_q == CH_IDLE) out = silence ^ invert;
        else                    out = bit_q ^ invert;
    end

endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
    import pwm_pair_pkg::*;
#(
    parameter int          DW      = 32,
    parameter int          AW      = 8,
    parameter logic [31:0] RNG_RST = 32'd10000,
    parameter logic [31:0] DAT_RST = 32'd2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              pwm_tick,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0]         en_w;
    logic [NUM_CH-1:0]         ms_w;
    logic [NUM_CH-1:0]         sil_w;
    logic [NUM_CH-1:0]         inv_w;
    logic [NUM_CH-1:0][DW-1:0] rng_w;
    logic [NUM_CH-1:0][DW-1:0] dat_w;

    pwm_regs #(
        .DW(DW), .AW(AW), .RNG_RST(RNG_RST), .DAT_RST(DAT_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .en_o      (en_w),
        .ms_o      (ms_w),
        .sil_o     (sil_w),
        .inv_o     (inv_w),
        .rng_o     (rng_w),
        .dat_o     (dat_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_chan #(.DW(DW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (pwm_tick),
            .en        (en_w[c]),
            .markspace (ms_w[c]),
            .silence   (sil_w[c]),
            .invert    (inv_w[c]),
            .rng       (rng_w[c]),
            .dat       (dat_w[c]),
            .out       (pwm_out[c])
        );
    end

endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk
    import pwm_pair_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [AW-1:0]             bus_addr,
    input logic [DW-1:0]             bus_rdata,
    input logic                      pwm_tick,
    input logic [NUM_CH-1:0]         pwm_out,
    input logic [NUM_CH-1:0]         en,
    input logic [NUM_CH-1:0]         ms,
    input logic [NUM_CH-1:0]         sil,
    input logic [NUM_CH-1:0]         inv,
    input logic [NUM_CH-1:0][DW-1:0] rng,
    input logic [NUM_CH-1:0][DW-1:0] dat
);

    assert_ctl_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(OFS_CTL)) |-> (bus_rdata[14] == 1'b0 && bus_rdata[6] == 1'b0
                                        && bus_rdata[DW-1:16] == '0));

    assert_quiet_between_ticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(pwm_tick) && {en, ms, sil, inv} == $past({en, ms, sil, inv})
         && $past({en, ms, sil, inv}) == $past({en, ms, sil, inv}, 2))
        |-> $stable(pwm_out));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(en[c])) |-> (pwm_out[c] == (sil[c] ^ inv[c])));

        assert_zero_dat_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(en[c]) && $past(pwm_tick) && $past(dat[c]) == '0 && !inv[c])
            |-> !pwm_out[c]);

        assert_full_dat_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(en[c], 2) && $past(en[c]) && $past(ms[c]) == $past(ms[c], 2)
             && $past(pwm_tick) && $past(dat[c]) != '0 && $past(dat[c] >= rng[c])
             && !inv[c])
            |-> pwm_out[c]);
    end

endmodule

bind pwm_pair pwm_pair_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pwm_tick  (pwm_tick),
    .pwm_out   (pwm_out),
    .en        (en_w),
    .ms        (ms_w),
    .sil       (sil_w),
    .inv       (inv_w),
    .rng       (rng_w),
    .dat       (dat_w)
);

// File: tb/pwm_pair_test.sv
module pwm_pair_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          pwm_tick = 1'b0;
    logic [1:0]    pwm_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_pair uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_tick(pwm_tick),
        .pwm_out(pwm_out)
    );

    int n_checks = 0;
    int n_fail = 0;

    bit     c_en[2], c_ms[2], c_pol[2], c_sil[2];
    longint c_rng[2], c_dat[2];
    longint m_cnt[2], m_acc[2];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] ctl_word();
        logic [31:0] w = '0;
        for (int c = 0; c < 2; c++) begin
            w[8*c + 0] = c_en[c];
            w[8*c + 3] = c_sil[c];
            w[8*c + 4] = c_pol[c];
            w[8*c + 7] = c_ms[c];
        end
        return w;
    endfunction

    // one tick of the requirement model (R5, R6, R7, R8, R4)
    function automatic bit model_step(input int c);
        bit b;
        longint d, s;
        if (!c_en[c]) return c_sil[c] ^ c_pol[c];
        if (c_ms[c]) begin
            b = (c_dat[c] != 0) && ((m_cnt[c] < c_dat[c]) || (c_dat[c] >= c_rng[c]));
            m_cnt[c] = (m_cnt[c] + 1 >= c_rng[c]) ? 0 : m_cnt[c] + 1;
        end else begin
            d = (c_dat[c] > c_rng[c]) ? c_rng[c] : c_dat[c];
            s = m_acc[c] + d;
            b = (c_dat[c] != 0) && (s >= c_rng[c]);
            m_acc[c] = (s >= c_rng[c]) ? s - c_rng[c] : s;
        end
        return b ^ c_pol[c];
    endfunction

    function automatic logic [1:0] pre_tick_level();
        logic [1:0] v;
        for (int c = 0; c < 2; c++)
            v[c] = c_en[c] ? c_pol[c] : (c_sil[c] ^ c_pol[c]);
        return v;
    endfunction

    task automatic run(input string tag, input int nticks, input int maxgap);
        logic [1:0] last, exp;
        wr(8'h00, 32'h0);
        wr(8'h10, 32'(c_rng[0]));
        wr(8'h14, 32'(c_dat[0]));
        wr(8'h20, 32'(c_rng[1]));
        wr(8'h24, 32'(c_dat[1]));
        wr(8'h00, ctl_word());
        for (int c = 0; c < 2; c++) begin m_cnt[c] = 0; m_acc[c] = 0; end
        repeat (3) @(negedge clk);
        last = pre_tick_level();
        check({tag, " R8 pre-tick"}, 64'(pwm_out), 64'(last));
        for (int t = 0; t < nticks; t++) begin
            int gap = (maxgap > 0) ? int'($urandom_range(0, maxgap)) : 0;
            repeat (gap) begin
                @(negedge clk);
                check("R9 no tick", 64'(pwm_out), 64'(last));
            end
            pwm_tick = 1'b1;
            @(negedge clk);
            pwm_tick = 1'b0;
            exp[1] = model_step(1);
            exp[0] = model_step(0);
            check(tag, 64'(pwm_out), 64'(exp));
            last = exp;
        end
    endtask

    task automatic set_ch(input int c, input bit en, input bit ms, input bit pol,
                          input bit sil, input longint rng, input longint dat);
        c_en[c] = en; c_ms[c] = ms; c_pol[c] = pol; c_sil[c] = sil;
        c_rng[c] = rng; c_dat[c] = dat;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 out", 64'(pwm_out), 64'h0);
        rd(8'h00, v); check("R1 ctl", 64'(v), 64'h0);
        rd(8'h10, v); check("R1 rng0", 64'(v), 64'd10000);
        rd(8'h14, v); check("R1 dat0", 64'(v), 64'd2500);
        rd(8'h20, v); check("R1 rng1", 64'(v), 64'd10000);
        rd(8'h24, v); check("R1 dat1", 64'(v), 64'd2500);

        // R2 register map
        wr(8'h10, 32'h1234_5678); rd(8'h10, v); check("R2 rng0", 64'(v), 64'h1234_5678);
        wr(8'h24, 32'hCAFE_0001); rd(8'h24, v); check("R2 dat1", 64'(v), 64'hCAFE_0001);
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); check("R2 sta", 64'(v), 64'h0);
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, v); check("R2 hole", 64'(v), 64'h0);
        rd(8'h00, v); check("R2 ctl untouched", 64'(v), 64'h0);
        rd(8'h14, v); check("R2 dat0 untouched", 64'(v), 64'd2500);

        // R3 control readback mask
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); check("R3 ctl ones", 64'(v), 64'hBFBF);
        wr(8'h00, 32'h0000_2526); rd(8'h00, v); check("R3 ctl pattern", 64'(v), 64'h2526);
        wr(8'h00, 32'h0);

        // R4 silence level with inversion, ticks ignored
        set_ch(0, 0, 0, 0, 1, 10, 3); set_ch(1, 0, 0, 1, 0, 10, 3);
        run("R4 idle", 6, 1);
        set_ch(0, 0, 1, 1, 1, 10, 3); set_ch(1, 0, 1, 1, 1, 10, 3);
        run("R4 idle", 6, 1);

        // R5 mark/space
        set_ch(0, 1, 1, 0, 0, 10, 3); set_ch(1, 0, 0, 0, 1, 4, 1);
        run("R5 ch0", 25, 0);
        set_ch(0, 0, 0, 0, 0, 4, 1); set_ch(1, 1, 1, 0, 0, 7, 4);
        run("R5 ch1", 16, 1);

        // R6 spread
        set_ch(0, 1, 0, 0, 0, 10, 3); set_ch(1, 0, 0, 0, 0, 4, 1);
        run("R6 10/3", 25, 0);
        set_ch(0, 1, 0, 0, 0, 7, 5); set_ch(1, 1, 0, 0, 0, 9, 2);
        run("R6 7/5 9/2", 22, 1);

        // R7 extremes
        set_ch(0, 1, 1, 0, 0, 10, 0);  set_ch(1, 1, 0, 0, 0, 10, 0);
        run("R7 zero", 12, 0);
        set_ch(0, 1, 1, 0, 0, 10, 12); set_ch(1, 1, 0, 0, 0, 10, 10);
        run("R7 full", 12, 0);
        set_ch(0, 1, 0, 0, 0, 0, 5);   set_ch(1, 1, 1, 0, 0, 0, 0);
        run("R7 zero range", 6, 0);

        // R8 inversion while running
        set_ch(0, 1, 1, 1, 0, 6, 2); set_ch(1, 1, 0, 1, 1, 5, 2);
        run("R8 inverted", 15, 0);

        // R9 long gaps between ticks
        set_ch(0, 1, 0, 0, 1, 8, 3); set_ch(1, 1, 1, 0, 0, 5, 4);
        run("R9 gapped", 20, 3);

        // R10 restart from position 0 after disable / enable
        set_ch(0, 1, 1, 0, 0, 5, 2); set_ch(1, 1, 0, 0, 0, 5, 2);
        run("R10 first", 7, 0);
        run("R10 again", 7, 0);

        // R11 random, both channels independent
        for (int i = 0; i < 16; i++) begin
            for (int c = 0; c < 2; c++)
                set_ch(c, bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)),
                       bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                       longint'($urandom_range(1, 40)), longint'($urandom_range(0, 45)));
            run("R11 random", 40, 2);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule